// File: doc/BRIEF.md
# Infrared Serial Pulse Demodulator with Width Filter

This block turns the return-to-zero pulse train from an infrared detector into the level-coded bit stream that a UART receiver expects. The detector line rests high. A zero bit arrives as a short low pulse, and a one bit arrives as no pulse. The line first passes through a two-flop synchroniser. A counter then measures each low interval in prescaler periods, using an externally supplied prescaler tick. An interval that covers too few ticks is treated as a glitch and dropped. A qualified pulse pulls the NRZ output low, and the output stays low until the next bit-period tick. In this way a narrow pulse is widened into a full zero bit.

The block also emits a one-cycle start strobe. The strobe fires on the first qualified pulse after the line has carried no pulses for a programmable number of bit periods. The decoder is half duplex. While the local transmitter reports busy, the received line is ignored and the output rests at one. The decoder is also held off whenever the programmed prescaler value is zero.

Top module: `irda_sir_demod`

## Requirements
- R1: After reset, nrz_bit is 1 and start_pulse is 0.
- R2: A low interval on rx_line that contains at most one psc_tick is rejected: nrz_bit stays 1 and start_pulse stays 0. Any low interval shorter than one prescaler period falls in this case.
- R3: A low interval on rx_line that contains at least ACCEPT_TICKS psc_tick pulses (default 2) is accepted and drives nrz_bit to 0. Any interval longer than two prescaler periods falls in this case. nrz_bit falls only on an acceptance.
- R4: After an acceptance, nrz_bit stays 0 until a bit_tick arrives in a cycle without a new acceptance. nrz_bit is 1 in the cycle after that bit_tick.
- R5: start_pulse is high for exactly one cycle, together with the nrz_bit falling edge, when a pulse is accepted while the decoder is idle. The decoder is idle after reset.
- R6: An accepted pulse makes the decoder busy. It returns to idle only after IDLE_BITS consecutive bit_tick pulses (default 10) with no acceptance. Acceptances while busy give no start_pulse.
- R7: While tx_busy is 1, rx_line is ignored: no acceptance, no start_pulse, and nrz_bit is 1 from the next cycle.
- R8: While psc_value is 0, the decoder is disabled in the same way as in R7.
- R9: A single low interval is accepted at most once. If rx_line is still low when the releasing bit_tick arrives, nrz_bit returns to 1 and remains 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_line | input | 1 | Raw detector signal, idle high, active-low pulses |
| psc_tick | input | 1 | One-cycle strobe per prescaler period |
| bit_tick | input | 1 | One-cycle strobe per bit period |
| psc_value | input | PSC_W | Programmed prescaler value; zero disables decoding |
| tx_busy | input | 1 | Local transmitter active; blocks reception |
| nrz_bit | output | 1 | Decoded NRZ bit stream |
| start_pulse | output | 1 | One-cycle strobe on the first accepted pulse after idle |

## Verification
Each failure mode shows up at a different point. A width counter that fails to clear between intervals makes a later narrow glitch pass as a zero bit. The bench sees this as a low output within about twenty cycles of the glitch, where the output should stay high. A hold register that misses its release keeps the output low past the next bit tick, which is visible two cycles after that tick. A wrong idle tracker either repeats the start strobe on the next bit or withholds it after a long gap, so the strobe count after each pulse exposes it.

// File: rtl/irda_rx_pkg.sv
package irda_rx_pkg;
  typedef enum logic {
    FRAME_IDLE   = 1'b0,
    FRAME_ACTIVE = 1'b1
  } frame_state_e;
endpackage

// File: rtl/irda_sync2.sv
module irda_sync2 #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;
  logic stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RESET_VAL;
      stab_q <= RESET_VAL;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/irda_pulse_qual.sv
module irda_pulse_qual #(
  parameter int ACCEPT_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic line_low,
  input  logic psc_tick,
  output logic accept
);
  localparam int CNT_W = $clog2(ACCEPT_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(ACCEPT_TICKS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACCEPT_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             counting;

  assign counting = en && line_low;

  // Width counter: clears on high level or when disabled, saturates once
  // the threshold is reached so one interval yields one acceptance.
  always_comb begin
    cnt_d = cnt_q;
    if (!counting) begin
      cnt_d = '0;
    end else if (psc_tick && (cnt_q != CNT_SAT)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign accept = counting && psc_tick && (cnt_q == CNT_LAST);
endmodule

// File: rtl/irda_nrz_shaper.sv
module irda_nrz_shaper
  import irda_rx_pkg::*;
#(
  parameter int IDLE_BITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic accept,
  input  logic bit_tick,
  output logic nrz_bit,
  output logic start_pulse
);
  localparam int GAP_W = $clog2(IDLE_BITS + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(IDLE_BITS - 1);

  logic             nrz_q, nrz_d;
  logic             strobe_q, strobe_d;
  frame_state_e     state_q, state_d;
  logic [GAP_W-1:0] gap_q, gap_d;

  // Output level: acceptance wins over release in the same cycle.
  always_comb begin
    nrz_d = nrz_q;
    if (!en) begin
      nrz_d = 1'b1;
    end else if (accept) begin
      nrz_d = 1'b0;
    end else if (bit_tick) begin
      nrz_d = 1'b1;
    end
  end

  // Idle tracker: counts quiet bit periods after the last acceptance.
  always_comb begin
    state_d = state_q;
    gap_d   = gap_q;
    if (accept) begin
      state_d = FRAME_ACTIVE;
      gap_d   = '0;
    end else if (bit_tick && (state_q == FRAME_ACTIVE)) begin
      if (gap_q == GAP_LAST) begin
        state_d = FRAME_IDLE;
        gap_d   = '0;
      end else begin
        gap_d = gap_q + 1'b1;
      end
    end
  end

  assign strobe_d = accept && (state_q == FRAME_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nrz_q    <= 1'b1;
      strobe_q <= 1'b0;
      state_q  <= FRAME_IDLE;
      gap_q    <= '0;
    end else begin
      nrz_q    <= nrz_d;
      strobe_q <= strobe_d;
      state_q  <= state_d;
      gap_q    <= gap_d;
    end
  end

  assign nrz_bit     = nrz_q;
  assign start_pulse = strobe_q;
endmodule

// File: rtl/irda_sir_demod.sv
module irda_sir_demod #(
  parameter int PSC_W        = 5,
  parameter int ACCEPT_TICKS = 2,
  parameter int IDLE_BITS    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_line,
  input  logic             psc_tick,
  input  logic             bit_tick,
  input  logic [PSC_W-1:0] psc_value,
  input  logic             tx_busy,
  output logic             nrz_bit,
  output logic             start_pulse
);
  logic rst_meta_q;
  logic rst_sync_q;
  logic line_sync;
  logic enable;
  logic accept;

  // Reset asserts asynchronously, deasserts on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign enable = (psc_value != '0) && !tx_busy;

  irda_sync2 #(.RESET_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .d     (rx_line),
    .q     (line_sync)
  );

  irda_pulse_qual #(.ACCEPT_TICKS(ACCEPT_TICKS)) u_qual (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .en       (enable),
    .line_low (!line_sync),
    .psc_tick (psc_tick),
    .accept   (accept)
  );

  irda_nrz_shaper #(.IDLE_BITS(IDLE_BITS)) u_shape (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .en          (enable),
    .accept      (accept),
    .bit_tick    (bit_tick),
    .nrz_bit     (nrz_bit),
    .start_pulse (start_pulse)
  );
endmodule

// File: rtl/irda_sir_demod_chk.sv
module irda_sir_demod_chk #(
  parameter int PSC_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_tick,
  input logic [PSC_W-1:0] psc_value,
  input logic             tx_busy,
  input logic             accept,
  input logic             nrz_bit,
  input logic             start_pulse
);
  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  p_strobe_with_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> !nrz_bit);

  p_fall_needs_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nrz_bit) |-> $past(accept));

  p_release_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !accept) |=> nrz_bit);

  p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |=> (nrz_bit && !start_pulse));

  p_zero_psc_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (psc_value == '0) |=> (nrz_bit && !start_pulse));
endmodule

bind irda_sir_demod irda_sir_demod_chk #(.PSC_W(PSC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_q),
  .bit_tick    (bit_tick),
  .psc_value   (psc_value),
  .tx_busy     (tx_busy),
  .accept      (accept),
  .nrz_bit     (nrz_bit),
  .start_pulse (start_pulse)
);

// File: tb/irda_sir_demod_tb.sv
`timescale 1ns/1ps
module irda_sir_demod_tb_top;
  localparam int PSC_W   = 5;
  localparam int PSC_PER = 8;
  localparam int BIT_PER = 64;

  logic             clk;
  logic             rst_n;
  logic             rx_line;
  logic             psc_tick;
  logic             bit_tick;
  logic [PSC_W-1:0] psc_value;
  logic             tx_busy;
  logic             nrz_bit;
  logic             start_pulse;

  int checks;
  int errors;
  int low_cnt;
  int strb_cnt;
  int cyc;
  bit done;

  irda_sir_demod #(.PSC_W(PSC_W)) dut_i (
    .clk (clk), .rst_n (rst_n), .rx_line (rx_line), .psc_tick (psc_tick),
    .bit_tick (bit_tick), .psc_value (psc_value), .tx_busy (tx_busy),
    .nrz_bit (nrz_bit), .start_pulse (start_pulse)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Tick generators and output monitor, all on the falling edge.
  initial begin
    cyc = 0; psc_tick = 1'b0; bit_tick = 1'b0; low_cnt = 0; strb_cnt = 0;
    forever begin
      @(negedge clk);
      cyc++;
      psc_tick = (cyc % PSC_PER) == 0;
      bit_tick = (cyc % BIT_PER) == 0;
      if (rst_n && !nrz_bit) low_cnt++;
      if (rst_n && start_pulse) strb_cnt++;
      if (cyc > 150000 && !done) begin
        done = 1;
        errors++;
        $display("FAIL watchdog: actual cycle %0d expected end before 150000", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_range(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk);
    low_cnt = 0; strb_cnt = 0;
  endtask

  task automatic align_bit();
    do @(posedge clk); while (!bit_tick);
  endtask

  task automatic wait_idle();
    repeat (12 * BIT_PER) @(negedge clk);
  endtask

  task automatic send_low(input int len);
    @(negedge clk);
    rx_line = 1'b0;
    repeat (len) @(negedge clk);
    rx_line = 1'b1;
  endtask

  task automatic t_reset();
    #1;
    check("R1 nrz_bit in reset", nrz_bit, 1);
    check("R1 start_pulse in reset", start_pulse, 0);
  endtask

  task automatic t_glitch(input int len);
    clear_mon();
    send_low(len);
    repeat (BIT_PER + 16) @(negedge clk);
    check("R2 glitch low cycles", low_cnt, 0);
    check("R2 glitch strobes", strb_cnt, 0);
  endtask

  task automatic t_accept_hold();
    wait_idle();
    clear_mon();
    align_bit();
    @(negedge clk);
    rx_line = 1'b0;
    repeat (24) @(negedge clk);
    rx_line = 1'b1;
    repeat (6) @(negedge clk);
    check("R3 accepted pulse drives zero", nrz_bit, 0);
    align_bit();
    check("R4 still zero before release", nrz_bit, 0);
    @(negedge clk); @(negedge clk);
    check("R4 one after bit tick", nrz_bit, 1);
    check_range("R4 zero stretched to bit boundary", low_cnt, 40, 64);
    check("R5 single strobe from idle", strb_cnt, 1);
  endtask

  task automatic t_busy_frame();
    clear_mon();
    align_bit();
    send_low(24);
    repeat (BIT_PER) @(negedge clk);
    check_range("R6 pulse in frame accepted", low_cnt, 40, 64);
    check("R6 no strobe while frame busy", strb_cnt, 0);
    wait_idle();
    clear_mon();
    send_low(24);
    repeat (BIT_PER + 8) @(negedge clk);
    check("R6 strobe after idle gap", strb_cnt, 1);
  endtask

  task automatic t_tx_busy();
    wait_idle();
    tx_busy = 1'b1;
    clear_mon();
    send_low(40);
    repeat (BIT_PER) @(negedge clk);
    check("R7 busy low cycles", low_cnt, 0);
    check("R7 busy strobes", strb_cnt, 0);
    tx_busy = 1'b0;
  endtask

  task automatic t_psc_zero();
    psc_value = '0;
    clear_mon();
    send_low(40);
    repeat (BIT_PER) @(negedge clk);
    check("R8 zero prescaler low cycles", low_cnt, 0);
    check("R8 zero prescaler strobes", strb_cnt, 0);
    psc_value = 5'd4;
  endtask

  task automatic t_long_low();
    wait_idle();
    clear_mon();
    align_bit();
    @(negedge clk);
    rx_line = 1'b0;
    repeat (70) @(negedge clk);
    check("R9 released while line still low", nrz_bit, 1);
    repeat (30) @(negedge clk);
    rx_line = 1'b1;
    repeat (BIT_PER) @(negedge clk);
    check_range("R9 one acceptance per interval", low_cnt, 40, 64);
    check("R9 strobe count", strb_cnt, 1);
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; rx_line = 1'b1; psc_value = 5'd4; tx_busy = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_glitch(1);
    t_glitch(6);
    t_accept_hold();
    t_busy_frame();
    t_tx_busy();
    t_psc_zero();
    t_long_low();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule